// File: doc/BRIEF.md
# FIFO Threshold Request and Stall-Error Monitor

This block sits beside a read FIFO and a write FIFO placed between a processor bus and an external-memory sequencer. It takes the occupancy count of each FIFO and produces one service request line per FIFO, for use as an interrupt or a DMA request. The read side asks to be drained once it holds at least the programmed amount of data. The write side asks to be filled once it holds no more than its programmed amount. Both sides can select the fully-empty point and the fully-full point, so that blocking transfers can run without wait states.

The block also watches the bus strobes for two latency events. The first is a write attempted while the write FIFO is full. The second is a read that was held back because earlier writes were still queued. Each event has an enable bit in the control word. Each sets a sticky flag, and the flags together drive an error interrupt. A full write FIFO also holds the write-ready output low until a slot frees. The read stall is not prevented; it is only reported after the read completes.

Top module: `fifo_svc_monitor`

## Requirements
- R1: After reset the control word reads 0x00000033. Bits 2:0 hold the read level code and bits 6:4 hold the write level code, both 3 after reset. Bit 16 is the read-stall error enable and bit 17 is the write-full error enable, both 0 after reset. Every other bit reads 0. A write with `cfg_we` high loads these fields from `cfg_wdata` on the next clock edge.
- R2: `rd_req` is high exactly when `rd_req_en` is high and `rd_count` is greater than or equal to the read threshold.
- R3: `wr_req` is high exactly when `wr_req_en` is high and `wr_count` is less than or equal to the write threshold.
- R4: With the default depth of 8, level codes map to these thresholds: code 0 to 0 (empty), code 1 to 2, code 2 to 4, code 3 to 6, and codes 4 to 7 to 8 (full).
- R5: `wr_ready` is low exactly while `wr_count` equals the FIFO depth.
- R6: When bit 17 is set, a write strobe held while the write FIFO is full sets `err_wfull` at the clock edge ending the first cycle of that attempt, and later cycles of the same held attempt raise no new event. When bit 17 is clear, such a write raises no error.
- R7: When bit 16 is set at the cycle of a read strobe and `wr_count` is nonzero in that cycle, the read is marked as stalled. `err_rstall` is then set at the clock edge where `rd_done` is high. A read strobe seen while `wr_count` is zero, or while bit 16 is clear, does not set the flag.
- R8: Both error flags are sticky. `err_clr` bit 0 clears `err_rstall` and bit 1 clears `err_wfull` at the next edge. A set in the same cycle wins over a clear.
- R9: `err_irq` is the OR of `err_wfull` and `err_rstall`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word readback |
| err_clr | input | 2 | Write-1 clear: bit 0 read-stall flag, bit 1 write-full flag |
| rd_count | input | CNT_W (4) | Read FIFO occupancy |
| wr_count | input | CNT_W (4) | Write FIFO occupancy |
| rd_req_en | input | 1 | Read request enable (DMA active or interrupt enabled) |
| wr_req_en | input | 1 | Write request enable (DMA active or interrupt enabled) |
| bus_wr_strobe | input | 1 | Bus write attempt, held while stalled |
| bus_rd_strobe | input | 1 | Bus read start, one cycle per read |
| bus_rd_done | input | 1 | Read data returned |
| wr_ready | output | 1 | Write may complete (write FIFO not full) |
| rd_req | output | 1 | Read FIFO service request |
| wr_req | output | 1 | Write FIFO service request |
| err_wfull | output | 1 | Sticky write-full error flag |
| err_rstall | output | 1 | Sticky read-stall error flag |
| err_irq | output | 1 | Error interrupt |

## Verification
The assertions assume that the occupancy counts never exceed the FIFO depth. They also assume that a stalled write keeps its strobe high until `wr_ready` returns, and that each read presents a one-cycle strobe before its completion. The stimulus keeps the counts in the range 0 to 8 by taking them modulo nine. The pseudo-random phase drives strobes, completions and clears freely, and the reference model defines the result for every combination, including a strobe and a completion in the same cycle. The directed phases sweep every level code against every count, and they place a clear in the same cycle as a new error event.

// File: rtl/fifo_svc_pkg.sv
// Package: shared control-word type and level-code decoding.
// Assumes FIFO depth is a multiple of four.
package fifo_svc_pkg;

    typedef struct packed {
        logic       wfull_en;
        logic       rstall_en;
        logic [2:0] wr_lvl;
        logic [2:0] rd_lvl;
    } svc_cfg_t;

    // Level code to entry threshold: quarters of depth, codes 4..7 are full (R4)
    function automatic int unsigned lvl_to_thr(input logic [2:0] code,
                                               input int unsigned depth);
        int unsigned t;
        if (code >= 3'd4) t = depth;
        else              t = (depth / 4) * int'(code);
        return t;
    endfunction

endpackage

// File: rtl/fifo_svc_cfg.sv
// Control word register: holds level codes and error enables.
// Assumes single-cycle writes; the unused bits are not stored.
module fifo_svc_cfg
    import fifo_svc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    output svc_cfg_t    cfg,
    output logic [31:0] cfg_rdata
);

    svc_cfg_t cfg_q;

    // Load the control fields on a write; reset to level 3 / errors off
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{wfull_en: 1'b0, rstall_en: 1'b0, wr_lvl: 3'd3, rd_lvl: 3'd3};
        end else if (cfg_we) begin
            cfg_q.wfull_en  <= cfg_wdata[17];
            cfg_q.rstall_en <= cfg_wdata[16];
            cfg_q.wr_lvl    <= cfg_wdata[6:4];
            cfg_q.rd_lvl    <= cfg_wdata[2:0];
        end
    end

    // Readback with unused bits forced to zero
    always_comb begin
        cfg_rdata     = '0;
        cfg_rdata[17] = cfg_q.wfull_en;
        cfg_rdata[16] = cfg_q.rstall_en;
        cfg_rdata[6:4] = cfg_q.wr_lvl;
        cfg_rdata[2:0] = cfg_q.rd_lvl;
    end

    assign cfg = cfg_q;

    // R1: the cycle after reset the word holds its reset value
    a_r1_reset_word: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (cfg_rdata == 32'h0000_0033));

    // R1: without a write the word holds
    a_r1_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cfg_we)) |-> $stable(cfg_rdata));

endmodule

// File: rtl/fifo_svc_level.sv
// Threshold comparator for one FIFO. IS_READ=1 triggers at or above the
// level (fullness), IS_READ=0 triggers at or below it (room to fill).
// Assumes count never exceeds DEPTH.
module fifo_svc_level
    import fifo_svc_pkg::*;
#(
    parameter int unsigned DEPTH   = 8,
    parameter bit          IS_READ = 1'b1,
    localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       lvl,
    input  logic [CNT_W-1:0] count,
    input  logic             req_en,
    output logic             req
);

    logic [CNT_W-1:0] thr;
    logic             hit;

    // Decode the level code into an entry count
    always_comb thr = CNT_W'(lvl_to_thr(lvl, DEPTH));

    // Direction chosen at elaboration time
    generate
        if (IS_READ) begin : g_rd
            assign hit = (count >= thr);
        end else begin : g_wr
            assign hit = (count <= thr);
        end
    endgenerate

    assign req = req_en && hit;

    // R2 R3: a disabled request stays low
    a_r2_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !req_en |-> !req);

    generate
        if (IS_READ) begin : g_ard
            // R2: a full read FIFO always requests service when enabled
            a_r2_full: assert property (@(posedge clk) disable iff (!rst_n)
                (req_en && count == CNT_W'(DEPTH)) |-> req);
        end else begin : g_awr
            // R3: an empty write FIFO always requests data when enabled
            a_r3_empty: assert property (@(posedge clk) disable iff (!rst_n)
                (req_en && count == '0) |-> req);
        end
    endgenerate

endmodule

// File: rtl/fifo_svc_err.sv
// Latency error monitor: write into full FIFO and read stalled behind
// queued writes. Flags are sticky with write-1 clear; set wins.
// Assumes a stalled write holds its strobe and each read strobes once.
module fifo_svc_err #(
    parameter int unsigned DEPTH  = 8,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wfull_en,
    input  logic             rstall_en,
    input  logic [CNT_W-1:0] wr_count,
    input  logic             bus_wr_strobe,
    input  logic             bus_rd_strobe,
    input  logic             bus_rd_done,
    input  logic [1:0]       err_clr,
    output logic             wr_ready,
    output logic             err_wfull,
    output logic             err_rstall
);

    logic wfull_now;
    logic held_q;
    logic pend_q;
    logic set_wfull;
    logic set_rstall;

    assign wfull_now  = (wr_count == CNT_W'(DEPTH));
    assign wr_ready   = !wfull_now;
    assign set_wfull  = wfull_en && bus_wr_strobe && wfull_now && !held_q;
    assign set_rstall = bus_rd_done && pend_q;

    // Remember that the current write attempt is already stalled
    always_ff @(posedge clk) begin
        if (!rst_n) held_q <= 1'b0;
        else        held_q <= bus_wr_strobe && wfull_now;
    end

    // Mark a read issued with writes queued ahead of it until it returns
    always_ff @(posedge clk) begin
        if (!rst_n)                                              pend_q <= 1'b0;
        else if (bus_rd_strobe && rstall_en && wr_count != '0)   pend_q <= 1'b1;
        else if (bus_rd_done)                                    pend_q <= 1'b0;
    end

    // Sticky error flags, new event beats a clear (R8)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_wfull  <= 1'b0;
            err_rstall <= 1'b0;
        end else begin
            err_wfull  <= (err_wfull  && !err_clr[1]) || set_wfull;
            err_rstall <= (err_rstall && !err_clr[0]) || set_rstall;
        end
    end

    // R6: the write-full flag only rises after a write hit a full FIFO
    a_r6_wfull_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_wfull) |-> $past(bus_wr_strobe && wr_count == CNT_W'(DEPTH) && wfull_en));

    // R7: the read-stall flag only rises at a read completion
    a_r7_rstall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_rstall) |-> $past(bus_rd_done));

    // R8: a flag without a clear stays set
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_wfull && !err_clr[1]) |=> err_wfull);

    // R5: ready is low whenever the write FIFO is full
    a_r5_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_count == CNT_W'(DEPTH)) |-> !wr_ready);

endmodule

// File: rtl/fifo_svc_monitor.sv
// Top: FIFO threshold service requests plus latency error monitor.
// Assumes occupancy counts come from FIFOs of depth DEPTH.
module fifo_svc_monitor
    import fifo_svc_pkg::*;
#(
    parameter int unsigned DEPTH  = 8,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    input  logic [1:0]       err_clr,
    input  logic [CNT_W-1:0] rd_count,
    input  logic [CNT_W-1:0] wr_count,
    input  logic             rd_req_en,
    input  logic             wr_req_en,
    input  logic             bus_wr_strobe,
    input  logic             bus_rd_strobe,
    input  logic             bus_rd_done,
    output logic             wr_ready,
    output logic             rd_req,
    output logic             wr_req,
    output logic             err_wfull,
    output logic             err_rstall,
    output logic             err_irq
);

    svc_cfg_t cfg;

    fifo_svc_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg       (cfg),
        .cfg_rdata (cfg_rdata)
    );

    fifo_svc_level #(.DEPTH(DEPTH), .IS_READ(1'b1)) u_rd_lvl (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl    (cfg.rd_lvl),
        .count  (rd_count),
        .req_en (rd_req_en),
        .req    (rd_req)
    );

    fifo_svc_level #(.DEPTH(DEPTH), .IS_READ(1'b0)) u_wr_lvl (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl    (cfg.wr_lvl),
        .count  (wr_count),
        .req_en (wr_req_en),
        .req    (wr_req)
    );

    fifo_svc_err #(.DEPTH(DEPTH)) u_err (
        .clk           (clk),
        .rst_n         (rst_n),
        .wfull_en      (cfg.wfull_en),
        .rstall_en     (cfg.rstall_en),
        .wr_count      (wr_count),
        .bus_wr_strobe (bus_wr_strobe),
        .bus_rd_strobe (bus_rd_strobe),
        .bus_rd_done   (bus_rd_done),
        .err_clr       (err_clr),
        .wr_ready      (wr_ready),
        .err_wfull     (err_wfull),
        .err_rstall    (err_rstall)
    );

    // Error interrupt combines both sticky flags (R9)
    assign err_irq = err_wfull || err_rstall;

    // R9: no interrupt without a flag
    a_r9_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_wfull && !err_rstall) |-> !err_irq);

endmodule

// File: tb/tb_fifo_svc_monitor.sv
module tb_fifo_svc_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;
    localparam int WDOG = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [1:0]  err_clr = '0;
    logic [3:0]  rd_count = '0;
    logic [3:0]  wr_count = '0;
    logic        rd_req_en = 1'b0, wr_req_en = 1'b0;
    logic        bus_wr_strobe = 1'b0, bus_rd_strobe = 1'b0, bus_rd_done = 1'b0;
    logic        wr_ready, rd_req, wr_req, err_wfull, err_rstall, err_irq;

    fifo_svc_monitor #(.DEPTH(DEPTH)) dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit started = 0, done_flag = 0;

    // Reference model state
    int  m_rlvl, m_wlvl;
    bit  m_wen, m_ren, m_wf, m_rs, m_held, m_pend;

    function automatic int thr_of(int code);
        case (code)
            0: return 0;
            1: return 2;
            2: return 4;
            3: return 6;
            default: return 8;
        endcase
    endfunction

    // Model update at each edge from the inputs before the edge
    always @(posedge clk) begin
        bit full;
        full = (wr_count == DEPTH);
        started = 1;
        if (!rst_n) begin
            m_rlvl = 3; m_wlvl = 3; m_wen = 0; m_ren = 0;
            m_wf = 0; m_rs = 0; m_held = 0; m_pend = 0;
        end else begin
            bit sw, sr;
            sw = m_wen && bus_wr_strobe && full && !m_held;
            sr = bus_rd_done && m_pend;
            m_wf = (m_wf && !err_clr[1]) || sw;
            m_rs = (m_rs && !err_clr[0]) || sr;
            m_held = bus_wr_strobe && full;
            if (bus_rd_strobe && m_ren && wr_count != 0) m_pend = 1;
            else if (bus_rd_done) m_pend = 0;
            if (cfg_we) begin
                m_wen = cfg_wdata[17]; m_ren = cfg_wdata[16];
                m_wlvl = int'(cfg_wdata[6:4]); m_rlvl = int'(cfg_wdata[2:0]);
            end
        end
    end

    task automatic cmp(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    // Compare every output against the model on the falling edge
    always @(negedge clk) begin
        if (started && !done_flag) begin
            logic [31:0] exp_word;
            exp_word = '0;
            exp_word[17] = m_wen; exp_word[16] = m_ren;
            exp_word[6:4] = 3'(m_wlvl); exp_word[2:0] = 3'(m_rlvl);
            cmp("R1", "cfg_rdata", int'(cfg_rdata), int'(exp_word));
            cmp("R2", "rd_req", int'(rd_req), int'(rd_req_en && (int'(rd_count) >= thr_of(m_rlvl))));
            cmp("R3", "wr_req", int'(wr_req), int'(wr_req_en && (int'(wr_count) <= thr_of(m_wlvl))));
            cmp("R5", "wr_ready", int'(wr_ready), int'(wr_count != DEPTH));
            cmp("R6", "err_wfull", int'(err_wfull), int'(m_wf));
            cmp("R7", "err_rstall", int'(err_rstall), int'(m_rs));
            cmp("R9", "err_irq", int'(err_irq), int'(m_wf || m_rs));
        end
    end

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            cfg_we = 0; err_clr = '0; bus_rd_strobe = 0; bus_rd_done = 0;
        end
    endtask

    task automatic wcfg(bit wen, bit ren, int wl, int rl);
        cfg_wdata = '0;
        cfg_wdata[17] = wen; cfg_wdata[16] = ren;
        cfg_wdata[6:4] = 3'(wl); cfg_wdata[2:0] = 3'(rl);
        cfg_wdata[31] = 1'b1; cfg_wdata[3] = 1'b1; // unused bits read as zero (R1)
        cfg_we = 1;
        tick();
    endtask

    task automatic dchk(string tag, bit cond, int act, int exp);
        n_cmp++;
        if (!cond) begin
            n_bad++;
            $display("FAIL %s directed actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG && !done_flag) begin
            done_flag = 1;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        #2;
        tick(3);
        rst_n = 1;
        #1;
        dchk("R1", cfg_rdata == 32'h33, int'(cfg_rdata), 32'h33);
        // R4: sweep every level code against every count on both sides
        rd_req_en = 1; wr_req_en = 1;
        for (int code = 0; code < 8; code++) begin
            wcfg(0, 0, code, code);
            for (int c = 0; c <= DEPTH; c++) begin
                rd_count = 4'(c); wr_count = 4'(DEPTH - c);
                #1;
                dchk("R4", rd_req == (c >= thr_of(code)), int'(rd_req), int'(c >= thr_of(code)));
                tick();
            end
        end
        // R2 R3: enables gate the requests
        rd_req_en = 0; wr_req_en = 0; rd_count = 8; wr_count = 0;
        tick(2);
        rd_req_en = 1; wr_req_en = 1;
        tick(2);
        // R6: full write with error disabled, then enabled, held stall
        wcfg(0, 0, 3, 3);
        wr_count = DEPTH; bus_wr_strobe = 1;
        tick(3);
        bus_wr_strobe = 0; tick();
        wcfg(1, 1, 3, 3);
        bus_wr_strobe = 1; tick(4);
        wr_count = 5; tick(); bus_wr_strobe = 0; tick();
        dchk("R6", err_wfull == 1, int'(err_wfull), 1);
        // R8: clear, then clear together with a new event
        err_clr = 2'b10; tick();
        dchk("R8", err_wfull == 0, int'(err_wfull), 0);
        wr_count = DEPTH; bus_wr_strobe = 1; err_clr = 2'b10; tick();
        dchk("R8", err_wfull == 1, int'(err_wfull), 1);
        bus_wr_strobe = 0; wr_count = 2; tick();
        // R7: read behind queued writes, then read with empty write FIFO
        bus_rd_strobe = 1; tick(2);
        bus_rd_done = 1; tick();
        dchk("R7", err_rstall == 1, int'(err_rstall), 1);
        err_clr = 2'b11; tick();
        wr_count = 0; bus_rd_strobe = 1; tick(2);
        bus_rd_done = 1; tick();
        dchk("R7", err_rstall == 0, int'(err_rstall), 0);
        // Pseudo-random phase
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rd_count = 4'(lfsr[7:0] % 9);
            wr_count = (lfsr[3:0] > 11) ? 4'(DEPTH) : 4'(lfsr[15:8] % 9);
            rd_req_en = lfsr[1]; wr_req_en = lfsr[4];
            bus_wr_strobe = lfsr[5] | lfsr[9];
            bus_rd_strobe = lfsr[6] & lfsr[2];
            bus_rd_done = lfsr[11] & lfsr[0];
            err_clr = (lfsr[14:12] == 3'd0) ? lfsr[9:8] : 2'b00;
            if (lfsr[15:11] == 5'd3) begin
                cfg_wdata = {lfsr, lfsr}; cfg_we = 1;
            end
            @(posedge clk); #2;
            cfg_we = 0;
        end
        tick(2);
        done_flag = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule